// File: doc/BRIEF.md
# Wait-For-Interrupt/Event Standby Clock Controller

This block decides when a processor core may stop its clock after a wait-for-interrupt (WFI) or wait-for-event (WFE) request from the pipeline, and when the clock must return. The core stays powered throughout, so its state is retained while the clock enable is low. The controller records which kind of request put the core into standby. It uses that record to choose the wake sources: interrupts and debug requests wake the core from either kind of standby, while the event input wakes it only from a WFE standby.

An event that arrives while the core runs, or while it sleeps in WFI standby, is held in a one-bit pending register. A later WFE sees the held event, completes at once without stopping the clock, and consumes it. All pins are plain control and status levels. No data stream passes through the block, so there is no handshake at its edge.

Top module: `wfx_standby_ctrl`

## Requirements
- R1: Reset (asynchronous, active low `rst_n`) forces `standby` to 0 and `core_clk_en` to 1, clears the event pending bit and clears the record of the entry type. This holds even when reset arrives during standby.
- R2: While running, a `wfi_req` or `wfe_req` that is accepted puts the core into standby at the next clock edge. From then on `standby` is 1 and `core_clk_en` is 0 for as long as no wake source is active.
- R3: While in either kind of standby, any bit of `irq` or a high `dbg_req` is a wake condition.
- R4: While in standby entered through WFE, a high `evt_in` is a wake condition. The event is consumed and does not set the pending bit.
- R5: While in standby entered through WFI, `evt_in` is not a wake condition. The event sets the pending bit instead.
- R6: While running, `evt_in` sets the pending bit. A `wfe_req` while the pending bit is set, or while `evt_in` is high in the same cycle, does not enter standby. Every `wfe_req` accepted while running clears the pending bit.
- R7: `core_clk_en` goes to 1 in the same cycle in which a wake condition is present. `standby` goes to 0 at the following clock edge.
- R8: A `wfi_req` or `wfe_req` in a cycle where any `irq` bit or `dbg_req` is high does not enter standby.
- R9: `wfi_req` and `wfe_req` have no effect while the core is in standby.
- R10: When `wfi_req` and `wfe_req` are both high in the same running cycle, the request is treated as WFI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of the controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_req | input | 1 | One-cycle pulse: wait-for-interrupt executed |
| wfe_req | input | 1 | One-cycle pulse: wait-for-event executed |
| irq | input | IRQ_W | Interrupt lines, level sensitive; any bit wakes |
| dbg_req | input | 1 | Debug request, level sensitive |
| evt_in | input | 1 | Event input, sampled one cycle at a time |
| core_clk_en | output | 1 | Enable for the core clock gate; 1 = clock runs |
| standby | output | 1 | 1 while the core is in standby |

## Verification
The assertions take all inputs to be synchronous to `clk` and settled before each rising edge. They also take the wake sources to be levels that are sampled cycle by cycle. The stimulus changes every input on the falling edge and holds it for the whole following cycle. It treats `wfi_req` and `wfe_req` as single-cycle pulses. It raises both of them together only in the one step that exercises the WFI priority rule.

// File: rtl/wfx_pkg.sv
package wfx_pkg;
  // Operating mode; the two standby codes also record the entry type.
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WFI  = 2'd1,
    MODE_WFE  = 2'd2
  } wfx_mode_e;
endpackage

// File: rtl/wfx_wake_detect.sv
module wfx_wake_detect
  import wfx_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  wfx_mode_e        mode,
  input  logic [IRQ_W-1:0] irq,
  input  logic             dbg_req,
  input  logic             evt_in,
  output logic             hard_wake,
  output logic             wake
);
  logic irq_any;

  generate
    if (IRQ_W == 1) begin : g_single
      assign irq_any = irq[0];
    end else begin : g_multi
      assign irq_any = |irq;
    end
  endgenerate

  // Interrupts and debug wake from any standby kind.
  assign hard_wake = irq_any | dbg_req;

  always_comb begin
    unique case (mode)
      MODE_WFI: wake = hard_wake;
      MODE_WFE: wake = hard_wake | evt_in;
      default:  wake = 1'b0;
    endcase
  end
endmodule

// File: rtl/wfx_event_latch.sv
module wfx_event_latch
  import wfx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  wfx_mode_e mode,
  input  logic      evt_in,
  input  logic      wfe_take,
  output logic      evt_pend
);
  logic set_c;

  // Events are remembered while running or in WFI standby;
  // in WFE standby the event is the wake source and is consumed.
  assign set_c = evt_in & (mode != MODE_WFE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        evt_pend <= 1'b0;
    else if (wfe_take) evt_pend <= 1'b0;
    else if (set_c)    evt_pend <= 1'b1;
  end
endmodule

// File: rtl/wfx_mode_fsm.sv
module wfx_mode_fsm
  import wfx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wfi_req,
  input  logic      wfe_req,
  input  logic      hard_wake,
  input  logic      wake,
  input  logic      evt_in,
  input  logic      evt_pend,
  output wfx_mode_e mode,
  output logic      wfe_take
);
  wfx_mode_e mode_nx;
  logic      running;

  assign running  = (mode == MODE_RUN);
  // A WFE executed while running is always taken (and clears the latch).
  assign wfe_take = running & wfe_req & ~wfi_req;

  always_comb begin
    mode_nx = mode;
    if (running) begin
      if (wfi_req) begin
        if (!hard_wake) mode_nx = MODE_WFI;
      end else if (wfe_req) begin
        if (!hard_wake && !evt_pend && !evt_in) mode_nx = MODE_WFE;
      end
    end else if (wake) begin
      mode_nx = MODE_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MODE_RUN;
    else        mode <= mode_nx;
  end
endmodule

// File: rtl/wfx_standby_ctrl.sv
module wfx_standby_ctrl
  import wfx_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wfi_req,
  input  logic             wfe_req,
  input  logic [IRQ_W-1:0] irq,
  input  logic             dbg_req,
  input  logic             evt_in,
  output logic             core_clk_en,
  output logic             standby
);
  wfx_mode_e mode;
  logic      hard_wake;
  logic      wake;
  logic      evt_pend;
  logic      wfe_take;

  wfx_wake_detect #(.IRQ_W(IRQ_W)) u_wake (
    .mode      (mode),
    .irq       (irq),
    .dbg_req   (dbg_req),
    .evt_in    (evt_in),
    .hard_wake (hard_wake),
    .wake      (wake)
  );

  wfx_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wfi_req   (wfi_req),
    .wfe_req   (wfe_req),
    .hard_wake (hard_wake),
    .wake      (wake),
    .evt_in    (evt_in),
    .evt_pend  (evt_pend),
    .mode      (mode),
    .wfe_take  (wfe_take)
  );

  wfx_event_latch u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .evt_in   (evt_in),
    .wfe_take (wfe_take),
    .evt_pend (evt_pend)
  );

  assign standby     = (mode != MODE_RUN);
  assign core_clk_en = ~standby | wake;

  AST_SLEEP_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    standby && !hard_wake && !(evt_in && mode == MODE_WFE) |-> !core_clk_en); // R2
  AST_HARD_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    standby && hard_wake |-> core_clk_en); // R3
  AST_WFE_EVT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_WFE && evt_in |=> !standby && !evt_pend); // R4
  AST_WFI_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_WFI && evt_in && !hard_wake |=> standby && evt_pend); // R5
  AST_PEND_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    !standby && wfe_req && !wfi_req && evt_pend |=> !standby && !evt_pend); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    standby && core_clk_en |=> !standby); // R7
  AST_BLOCKED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    !standby && (wfi_req || wfe_req) && hard_wake |=> !standby); // R8
  AST_WFI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !standby && wfi_req && wfe_req && !hard_wake |=> mode == MODE_WFI); // R10
endmodule

// File: tb/tb_wfx_standby_ctrl.sv
module tb_wfx_standby_ctrl;
  localparam int IRQ_W = 4;
  // Entry layout: {wfi, wfe, irq[3:0], dbg, evt, exp_en, exp_sb}
  localparam int NV = 27;
  localparam logic [9:0] VEC [NV] = '{
    10'b0_0_0000_0_0_1_0, // 0 idle running
    10'b1_0_0000_0_0_1_0, // 1 WFI enters (R2)
    10'b0_0_0000_0_0_0_1, // 2 asleep, clock off (R2)
    10'b0_0_0000_0_1_0_1, // 3 event ignored in WFI (R5)
    10'b0_0_0000_0_0_0_1, // 4 still asleep (R5)
    10'b0_0_0001_0_0_1_1, // 5 irq wakes, enable same cycle (R3 R7)
    10'b0_0_0000_0_0_1_0, // 6 flag cleared next cycle (R7)
    10'b0_1_0000_0_0_1_0, // 7 WFE with latched event (R5 R6)
    10'b0_0_0000_0_0_1_0, // 8 no entry happened (R6)
    10'b0_1_0000_0_0_1_0, // 9 WFE enters, latch was cleared (R6)
    10'b0_0_0000_0_0_0_1, // 10 asleep WFE
    10'b0_0_0000_0_1_1_1, // 11 event wakes WFE (R4)
    10'b0_0_0000_0_0_1_0, // 12 running
    10'b0_1_0000_0_0_1_0, // 13 WFE enters, wake event not latched (R4)
    10'b0_0_0000_1_0_1_1, // 14 debug wakes (R3)
    10'b0_0_0000_0_0_1_0, // 15 running
    10'b1_0_0010_0_0_1_0, // 16 WFI with irq high (R8)
    10'b0_0_0000_0_0_1_0, // 17 no entry (R8)
    10'b0_1_0000_1_0_1_0, // 18 WFE with dbg high (R8)
    10'b0_1_0000_0_1_1_0, // 19 WFE with same-cycle event (R6)
    10'b0_1_0000_0_0_1_0, // 20 WFE enters (R6)
    10'b1_0_0000_0_0_0_1, // 21 WFI in standby ignored (R9)
    10'b0_0_1000_0_0_1_1, // 22 top irq bit wakes (R3)
    10'b1_1_0000_0_0_1_0, // 23 both requests -> WFI (R10)
    10'b0_0_0000_0_1_0_1, // 24 event does not wake: WFI kind (R10)
    10'b0_0_0000_1_0_1_1, // 25 debug wakes
    10'b0_0_0000_0_0_1_0  // 26 running
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi_req = 1'b0, wfe_req = 1'b0, dbg_req = 1'b0, evt_in = 1'b0;
  logic [IRQ_W-1:0] irq = '0;
  logic core_clk_en, standby;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wfx_standby_ctrl #(.IRQ_W(IRQ_W)) dut (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
    .irq(irq), .dbg_req(dbg_req), .evt_in(evt_in),
    .core_clk_en(core_clk_en), .standby(standby)
  );

  task automatic check(input string tag, input logic en_exp, input logic sb_exp);
    checks++;
    if (core_clk_en !== en_exp || standby !== sb_exp) begin
      errors++;
      $display("FAIL %s: en=%b sb=%b expected en=%b sb=%b",
               tag, core_clk_en, standby, en_exp, sb_exp);
    end
  endtask

  task automatic drive(input logic [7:0] v);
    @(negedge clk);
    {wfi_req, wfe_req, irq, dbg_req, evt_in} = v;
    #2;
  endtask

  initial begin
    #3;
    check("R1 reset state", 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][9:2]);
      check($sformatf("vector %0d (R2-R10)", i), VEC[i][1], VEC[i][0]);
    end
    // R1: reset during standby clears standby and the latched event
    drive(8'b0_0_0000_0_1);           // event while running -> latched
    drive(8'b1_0_0000_0_0);           // WFI enters
    drive(8'b0_0_0000_0_0);
    check("R1 pre-reset standby", 1'b0, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R1 reset in standby", 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(8'b0_1_0000_0_0);           // WFE: latch must be empty now
    check("R1 WFE request cycle", 1'b1, 1'b0);
    drive(8'b0_0_0000_0_0);
    check("R1 latch cleared by reset", 1'b0, 1'b1);
    drive(8'b0_0_0000_0_1);           // event wakes WFE (R4)
    check("R4 event wake after reset", 1'b1, 1'b1);
    drive(8'b0_0_0000_0_0);
    check("R7 flag clears", 1'b1, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule